// File: doc/BRIEF.md
# SDRAM Single-Write Sequencer with Automatic Precharge

This block turns one write request into the complete command sequence that a synchronous DRAM needs to store one data word and then close the row by itself. A request carries a bank, a row, a column, a data word and a byte mask. The block first opens the row. It then waits and issues a write command with the automatic-precharge address bit set, driving the data in that same cycle. Finally it holds off further requests until the same bank may legally be opened again. Only one beat is ever written per request.

All waits are worked out at elaboration. Each device timing value is given in picoseconds and converted to whole clock cycles by ceiling division with the clock period. The write is placed late enough for two things: the row-to-column delay is met, and the internal precharge, which starts one write-recovery time after the data cycle, cannot cut the minimum row-active time short. The next open is gated by the longer of two limits: precharge completion, and the open-to-open cycle time. A ready/valid handshake stalls the requester in the meantime.

Top module: `sdram_wr_ap_seq`

## Requirements
- R1: While reset is low and up to the first clock edge after it rises, CKE is high, CS# is high, RAS#/CAS#/WE# are all high, the DQ output enable is low, the DQ mask is all ones and busy is low with ready high.
- R2: A request taken (valid and ready high at a clock edge) makes the next cycle an open-row command: CS# low, (RAS#, CAS#, WE#) = (0, 1, 1), bank pins equal to the request bank and the address bus equal to the request row.
- R3: The write command, (RAS#, CAS#, WE#) = (1, 0, 0) with CS# low, appears exactly S cycles after the open-row cycle. Here S = max(ceil(tRCD/tCK), ceil(tRAS/tCK) − WRC) and WRC = 1 + ceil(tWRx/tCK), where tWRx is the write-recovery time beyond one clock.
- R4: In the write cycle, address bit 10 is 1, the low COL_W address bits hold the request column, every other address bit is 0, and the bank pins hold the request bank.
- R5: The DQ output enable is high only in the write cycle. In that cycle the data output equals the request data and the mask equals the request byte mask (a mask bit of 1 blocks its byte). In every other cycle the enable is low and the mask is all ones.
- R6: Outside the open-row and write cycles, every cycle after reset is a no-operation: CS# low and (RAS#, CAS#, WE#) = (1, 1, 1).
- R7: Busy is high from the open-row cycle through cycle N−2 after it and low in cycle N−1, where N = max(S + WRC + ceil(tRP/tCK), ceil(tRC/tCK)). Ready is always the inverse of busy.
- R8: A request held valid while busy is not taken. If it is presented without pause, its open-row command appears exactly N cycles after the previous one, and none appears in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Column to write |
| req_data | input | DQ_W | Data word |
| req_mask | input | DQ_W/8 | Byte mask, 1 blocks the byte |
| busy | output | 1 | Sequence in progress or bank not yet reusable |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Multiplexed row/column address |
| sd_dqm | output | DQ_W/8 | DQ byte mask |
| sd_dq_out | output | DQ_W | Data to drive onto DQ |
| sd_dq_oe | output | 1 | DQ output enable |

## Verification
The bench builds two instances. The first uses the default 7.5 ns slow-grade timings. There the row-active limit places the write at cycle 4, later than the row-to-column delay of 3 would allow, and the precharge and cycle-time limits meet at 9. The second instance uses a 4 ns period with a 40 ns row-to-column delay. That moves the write to cycle 10, gated by the row-to-column delay, and lets precharge completion (18) outlast the cycle time (17). Between them, both choices inside each of the two maxima are exercised.

// File: rtl/sdram_wr_pkg.sv
// Shared types and helpers for the single-write sequencer.
// Assumes: all timing arguments are positive integers.
package sdram_wr_pkg;

    // Internal command selector handed to the pin encoder.
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_WR  = 2'd2
    } sd_cmd_e;

    // Ceiling division used to turn picoseconds into clock cycles.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/sdram_wr_step_cnt.sv
// Cycle counter for the sequence position.
// Clears to zero on clr, otherwise advances by one while en is high.
// Assumes: the caller keeps en low once the sequence ends, so it never wraps.
module sdram_wr_step_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] count
);

    // Position register: clear has priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (clr)  count <= '0;
        else if (en)   count <= count + 1'b1;
    end

endmodule

// File: rtl/sdram_wr_pin_enc.sv
// Registered pin driver: maps the chosen command and its fields onto the
// DRAM command, address, mask and data pins one clock later.
// Assumes: ADDR_W > 10 and COL_W <= 10, so the column never overlaps bit 10.
module sdram_wr_pin_enc
    import sdram_wr_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13,
    parameter int DQ_W   = 16,
    parameter int DM_W   = DQ_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sd_cmd_e           cmd,
    input  logic [BA_W-1:0]   bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [DQ_W-1:0]   data,
    input  logic [DM_W-1:0]   mask,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic [DM_W-1:0]   dqm,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe
);

    localparam int AP_BIT = 10;

    logic [ADDR_W-1:0] col_addr;

    // Column address: column in the low bits, auto-precharge flag at bit 10.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_col_addr
        if (i < COL_W) begin : g_col
            assign col_addr[i] = col[i];
        end else if (i == AP_BIT) begin : g_ap
            assign col_addr[i] = 1'b1;
        end else begin : g_zero
            assign col_addr[i] = 1'b0;
        end
    end

    // Pin register: one command per cycle, idle pins are a masked no-op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n   <= 1'b1;
            ras_n  <= 1'b1;
            cas_n  <= 1'b1;
            we_n   <= 1'b1;
            ba     <= '0;
            addr   <= '0;
            dqm    <= '1;
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else begin
            cs_n   <= 1'b0;
            ras_n  <= 1'b1;
            cas_n  <= 1'b1;
            we_n   <= 1'b1;
            ba     <= '0;
            addr   <= '0;
            dqm    <= '1;
            dq_out <= '0;
            dq_oe  <= 1'b0;
            case (cmd)
                CMD_ACT: begin
                    ras_n <= 1'b0;
                    ba    <= bank;
                    addr  <= ADDR_W'(row);
                end
                CMD_WR: begin
                    cas_n  <= 1'b0;
                    we_n   <= 1'b0;
                    ba     <= bank;
                    addr   <= col_addr;
                    dqm    <= mask;
                    dq_out <= data;
                    dq_oe  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sdram_wr_ap_seq.sv
// Single-beat SDRAM write sequencer with automatic precharge.
// Takes one request at a time, opens the row, writes one word with
// address bit 10 set, then blocks new requests until both the precharge
// time and the open-to-open cycle time have passed.
// Assumes: timing values are in picoseconds, TCK_PS is the clock period,
// the device runs with burst length one and has been initialised.
module sdram_wr_ap_seq
    import sdram_wr_pkg::*;
#(
    parameter int TCK_PS  = 7500,
    parameter int TRCD_PS = 20000,
    parameter int TRAS_PS = 44000,
    parameter int TWR_PS  = 7000,
    parameter int TRP_PS  = 20000,
    parameter int TRC_PS  = 66000,
    parameter int BA_W    = 2,
    parameter int ROW_W   = 13,
    parameter int COL_W   = 10,
    parameter int ADDR_W  = 13,
    parameter int DQ_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [BA_W-1:0]     req_bank,
    input  logic [ROW_W-1:0]    req_row,
    input  logic [COL_W-1:0]    req_col,
    input  logic [DQ_W-1:0]     req_data,
    input  logic [DQ_W/8-1:0]   req_mask,
    output logic                busy,
    output logic                sd_cke,
    output logic                sd_cs_n,
    output logic                sd_ras_n,
    output logic                sd_cas_n,
    output logic                sd_we_n,
    output logic [BA_W-1:0]     sd_ba,
    output logic [ADDR_W-1:0]   sd_addr,
    output logic [DQ_W/8-1:0]   sd_dqm,
    output logic [DQ_W-1:0]     sd_dq_out,
    output logic                sd_dq_oe
);

    localparam int DM_W     = DQ_W / 8;
    localparam int RCD_CYC  = ceil_div(TRCD_PS, TCK_PS);
    localparam int RAS_CYC  = ceil_div(TRAS_PS, TCK_PS);
    localparam int WR_CYC   = 1 + ceil_div(TWR_PS, TCK_PS);
    localparam int RP_CYC   = ceil_div(TRP_PS, TCK_PS);
    localparam int RC_CYC   = ceil_div(TRC_PS, TCK_PS);
    localparam int WR_SLOT  = (RCD_CYC > RAS_CYC - WR_CYC) ? RCD_CYC : RAS_CYC - WR_CYC;
    localparam int CLOSE_AT = WR_SLOT + WR_CYC + RP_CYC;
    localparam int NEXT_ACT = (CLOSE_AT > RC_CYC) ? CLOSE_AT : RC_CYC;
    localparam int CNT_W    = $clog2(NEXT_ACT + 1);
    localparam int CHK_W    = CNT_W + 2;

    logic              busy_q;
    logic              accept;
    logic [CNT_W-1:0]  step;
    logic [BA_W-1:0]   bank_q;
    logic [COL_W-1:0]  col_q;
    logic [DQ_W-1:0]   data_q;
    logic [DM_W-1:0]   mask_q;
    sd_cmd_e           cmd_nxt;
    logic [BA_W-1:0]   bank_nxt;

    assign req_ready = !busy_q;
    assign busy      = busy_q;
    assign accept    = req_valid && req_ready;
    assign sd_cke    = 1'b1;

    // Busy flag: set on acceptance, cleared one cycle before the next open may be registered.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         busy_q <= 1'b0;
        else if (accept)                                    busy_q <= 1'b1;
        else if (busy_q && step == CNT_W'(NEXT_ACT - 2))    busy_q <= 1'b0;
    end

    // Request holding register for the fields used in the write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            col_q  <= '0;
            data_q <= '0;
            mask_q <= '1;
        end else if (accept) begin
            bank_q <= req_bank;
            col_q  <= req_col;
            data_q <= req_data;
            mask_q <= req_mask;
        end
    end

    // Next command: open on acceptance, write when the slot comes up, otherwise idle.
    always_comb begin
        cmd_nxt  = CMD_NOP;
        bank_nxt = bank_q;
        if (accept) begin
            cmd_nxt  = CMD_ACT;
            bank_nxt = req_bank;
        end else if (busy_q && step == CNT_W'(WR_SLOT - 1)) begin
            cmd_nxt  = CMD_WR;
        end
    end

    sdram_wr_step_cnt #(.CNT_W(CNT_W)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (busy_q),
        .count (step)
    );

    sdram_wr_pin_enc #(
        .BA_W   (BA_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W),
        .DQ_W   (DQ_W),
        .DM_W   (DM_W)
    ) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd_nxt),
        .bank   (bank_nxt),
        .row    (req_row),
        .col    (col_q),
        .data   (data_q),
        .mask   (mask_q),
        .cs_n   (sd_cs_n),
        .ras_n  (sd_ras_n),
        .cas_n  (sd_cas_n),
        .we_n   (sd_we_n),
        .ba     (sd_ba),
        .addr   (sd_addr),
        .dqm    (sd_dqm),
        .dq_out (sd_dq_out),
        .dq_oe  (sd_dq_oe)
    );

    // ---------------- assertions ----------------
    logic             pin_act;
    logic             pin_wr;
    logic [CHK_W-1:0] since_act;
    logic [CHK_W-1:0] since_wr;

    assign pin_act = !sd_cs_n && !sd_ras_n &&  sd_cas_n &&  sd_we_n;
    assign pin_wr  = !sd_cs_n &&  sd_ras_n && !sd_cas_n && !sd_we_n;

    // Saturating age of the last open-row command seen on the pins.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_act <= '1;
        else if (pin_act)           since_act <= CHK_W'(1);
        else if (since_act != '1)   since_act <= since_act + 1'b1;
    end

    // Saturating age of the last write command seen on the pins.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_wr <= '1;
        else if (pin_wr)            since_wr <= CHK_W'(1);
        else if (since_wr != '1)    since_wr <= since_wr + 1'b1;
    end

    a_r2_accept_opens: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (pin_act && sd_ba == $past(req_bank)));

    a_r3_write_after_rcd: assert property (@(posedge clk) disable iff (!rst_n)
        pin_wr |-> (since_act >= CHK_W'(RCD_CYC)));

    a_r3_write_keeps_ras: assert property (@(posedge clk) disable iff (!rst_n)
        pin_wr |-> (since_act + CHK_W'(WR_CYC) >= CHK_W'(RAS_CYC)));

    a_r4_ap_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        pin_wr |-> sd_addr[10]);

    a_r5_oe_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe == pin_wr);

    a_r8_open_after_rc: assert property (@(posedge clk) disable iff (!rst_n)
        pin_act |-> (since_act >= CHK_W'(RC_CYC)));

    a_r8_open_after_rp: assert property (@(posedge clk) disable iff (!rst_n)
        pin_act |-> (since_wr >= CHK_W'(WR_CYC + RP_CYC)));

    a_r8_no_open_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !pin_act);

endmodule

// File: tb/sdram_wr_ap_seq_tb_top.sv
// Directed bench: two instances with different timing sets, one task per scenario.
module sdram_wr_ap_seq_tb_top;

    function automatic int cdiv(input int n, input int d);
        return (n + d - 1) / d;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Instance A: defaults. Instance B: 4 ns period, 40 ns row-to-column.
    localparam int A_TCK = 7500, A_RCD = 20000;
    localparam int B_TCK = 4000, B_RCD = 40000;
    localparam int TRAS = 44000, TWR = 7000, TRP = 20000, TRC = 66000;

    function automatic int slot_of(input int tck, input int rcd);
        return imax(cdiv(rcd, tck), cdiv(TRAS, tck) - (1 + cdiv(TWR, tck)));
    endfunction
    function automatic int next_of(input int tck, input int rcd);
        return imax(slot_of(tck, rcd) + 1 + cdiv(TWR, tck) + cdiv(TRP, tck), cdiv(TRC, tck));
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]  vld = 2'b00;
    logic [1:0]  r_bank = '0;
    logic [12:0] r_row = '0;
    logic [9:0]  r_col = '0;
    logic [15:0] r_data = '0;
    logic [1:0]  r_mask = '0;

    logic        rdy [2], bsy [2], cke [2], csn [2], rasn [2], casn [2], wen [2], oe [2];
    logic [1:0]  ba [2], dqm [2];
    logic [12:0] addr [2];
    logic [15:0] dq [2];

    sdram_wr_ap_seq #(.TCK_PS(A_TCK), .TRCD_PS(A_RCD)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(vld[0]), .req_ready(rdy[0]),
        .req_bank(r_bank), .req_row(r_row), .req_col(r_col), .req_data(r_data),
        .req_mask(r_mask), .busy(bsy[0]), .sd_cke(cke[0]), .sd_cs_n(csn[0]),
        .sd_ras_n(rasn[0]), .sd_cas_n(casn[0]), .sd_we_n(wen[0]), .sd_ba(ba[0]),
        .sd_addr(addr[0]), .sd_dqm(dqm[0]), .sd_dq_out(dq[0]), .sd_dq_oe(oe[0]));

    sdram_wr_ap_seq #(.TCK_PS(B_TCK), .TRCD_PS(B_RCD)) dut_b (
        .clk(clk), .rst_n(rst_n), .req_valid(vld[1]), .req_ready(rdy[1]),
        .req_bank(r_bank), .req_row(r_row), .req_col(r_col), .req_data(r_data),
        .req_mask(r_mask), .busy(bsy[1]), .sd_cke(cke[1]), .sd_cs_n(csn[1]),
        .sd_ras_n(rasn[1]), .sd_cas_n(casn[1]), .sd_we_n(wen[1]), .sd_ba(ba[1]),
        .sd_addr(addr[1]), .sd_dqm(dqm[1]), .sd_dq_out(dq[1]), .sd_dq_oe(oe[1]));

    int n_checks = 0;
    int n_errs   = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] cmd_of(input int s);
        return {rasn[s], casn[s], wen[s]};
    endfunction

    // R1: reset state on both instances.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            chk(cke[s] === 1'b1, "R1 cke", cke[s], 1);
            chk(csn[s] === 1'b1, "R1 cs_n", csn[s], 1);
            chk(cmd_of(s) === 3'b111, "R1 cmd", cmd_of(s), 3'b111);
            chk(oe[s] === 1'b0 && dqm[s] === 2'b11, "R1 oe/dqm", {oe[s], dqm[s]}, 3'b011);
            chk(bsy[s] === 1'b0 && rdy[s] === 1'b1, "R1 busy/ready", {bsy[s], rdy[s]}, 2'b01);
        end
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Present a request on instance s and return once the open cycle is visible.
    task automatic present(input int s, input logic [1:0] b, input logic [12:0] r,
                           input logic [9:0] c, input logic [15:0] d, input logic [1:0] m);
        r_bank = b; r_row = r; r_col = c; r_data = d; r_mask = m;
        vld[s] = 1'b1;
        while (!rdy[s]) @(negedge clk);
        @(negedge clk);
    endtask

    // Walk one sequence from its open cycle (cycle 0) to cycle N-1.
    task automatic walk(input int s, input int w, input int n, input logic [1:0] b,
                        input logic [12:0] r, input logic [9:0] c,
                        input logic [15:0] d, input logic [1:0] m, input bit hold_next);
        chk(cmd_of(s) === 3'b011 && csn[s] === 1'b0, "R2 open cmd", {csn[s], cmd_of(s)}, 4'b0011);
        chk(ba[s] === b && addr[s] === r, "R2 open bank/row", {ba[s], addr[s]}, {b, r});
        chk(bsy[s] === 1'b1, "R7 busy at open", bsy[s], 1);
        for (int k = 1; k < n; k++) begin
            @(negedge clk);
            if (k == w) begin
                chk(cmd_of(s) === 3'b100 && csn[s] === 1'b0, "R3 write slot", {csn[s], cmd_of(s)}, 4'b0100);
                chk(addr[s] === ((13'd1 << 10) | 13'(c)) && ba[s] === b, "R4 write addr/bank",
                    {ba[s], addr[s]}, {b, (13'd1 << 10) | 13'(c)});
                chk(oe[s] === 1'b1 && dq[s] === d && dqm[s] === m, "R5 write data/mask",
                    {oe[s], dqm[s], dq[s]}, {1'b1, m, d});
            end else begin
                chk(cmd_of(s) === 3'b111 && csn[s] === 1'b0, "R6 nop", {csn[s], cmd_of(s)}, 4'b0111);
                chk(oe[s] === 1'b0 && dqm[s] === 2'b11, "R5 idle oe/dqm", {oe[s], dqm[s]}, 3'b011);
            end
            if (k == n - 2) chk(bsy[s] === 1'b1 && rdy[s] === 1'b0, "R7 busy held", {bsy[s], rdy[s]}, 2'b10);
            if (k == n - 1) chk(bsy[s] === 1'b0 && rdy[s] === 1'b1, "R7 busy released", {bsy[s], rdy[s]}, 2'b01);
        end
        if (!hold_next) vld[s] = 1'b0;
    endtask

    task automatic t_single(input int s, input int w, input int n, input logic [1:0] b,
                            input logic [12:0] r, input logic [9:0] c,
                            input logic [15:0] d, input logic [1:0] m);
        present(s, b, r, c, d, m);
        vld[s] = 1'b0;
        walk(s, w, n, b, r, c, d, m, 1'b0);
        @(negedge clk);
        chk(cmd_of(s) === 3'b111, "R6 nop after release", cmd_of(s), 3'b111);
    endtask

    // R8: second request held valid through busy opens exactly N cycles later.
    task automatic t_back_to_back(input int s, input int w, input int n);
        present(s, 2'd1, 13'h0AAA, 10'h155, 16'h1234, 2'b00);
        r_bank = 2'd2; r_row = 13'h1555; r_col = 10'h2AA; r_data = 16'hBEEF; r_mask = 2'b10;
        walk(s, w, n, 2'd1, 13'h0AAA, 10'h155, 16'h1234, 2'b00, 1'b1);
        @(negedge clk);
        vld[s] = 1'b0;
        chk(cmd_of(s) === 3'b011, "R8 open at cycle N", cmd_of(s), 3'b011);
        walk(s, w, n, 2'd2, 13'h1555, 10'h2AA, 16'hBEEF, 2'b10, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        #800000;
        n_errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_single(0, slot_of(A_TCK, A_RCD), next_of(A_TCK, A_RCD), 2'd3, 13'h1F0F, 10'h3FF, 16'hA5C3, 2'b01);
        t_single(1, slot_of(B_TCK, B_RCD), next_of(B_TCK, B_RCD), 2'd0, 13'h0001, 10'h000, 16'hFFFF, 2'b11);
        t_back_to_back(0, slot_of(A_TCK, A_RCD), next_of(A_TCK, A_RCD));
        t_back_to_back(1, slot_of(B_TCK, B_RCD), next_of(B_TCK, B_RCD));
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule